// File: doc/BRIEF.md
# Memory Type Resolver for Second-Stage Translated Accesses

This block picks the memory type for memory references made while a second stage of address translation is on. It serves two kinds of reference. The first is a fetch of the translation structures themselves, whose type comes from a field in the translation root pointer. The second is a guest access through a translated address, whose type is built from the final translation entry and from the attribute-table type of that access. A global cache-disable control bit overrides both kinds and forces uncacheable. The range-register mechanism plays no part in either result.

The caller presents the control bits, the pointer type field, the low byte of the final translation entry and the attribute-table type on one cycle. On the next clock the block presents a 3-bit memory type and a misconfiguration flag. Type codes throughout are UC=0, WC=1, WT=4, WP=5, WB=6, and UC-minus=7 (UC-minus appears on the attribute-table input only).

Top module: `mem_type_resolver`

## Requirements
- R1: Both outputs are registered with one cycle of latency. While reset is asserted and right after it, `mem_type` is UC (0) and `misconfig` is 0.
- R2: When `cache_dis` is 1, `mem_type` is UC for both structure fetches and translated accesses.
- R3: For a structure fetch (`struct_fetch`=1) with `cache_dis`=0 and a legal pointer type, `mem_type` equals `ptr_type` (0 gives UC, 6 gives WB) and `misconfig` is 0. The leaf, attribute-table and paging inputs have no effect on a structure fetch.
- R4: For a structure fetch, a pointer type other than 0 or 6 sets `misconfig` to 1 and `mem_type` to UC, whatever the value of `cache_dis`.
- R5: For a translated access (`struct_fetch`=0), the entry type is `leaf_lo[5:3]`. Codes 0, 1, 4, 5 and 6 are legal. Codes 2, 3 and 7 set `misconfig` to 1 and force `mem_type` to UC, whatever the value of `cache_dis`. `ptr_type` has no effect on a translated access.
- R6: For a translated access with `cache_dis`=0, a legal entry type and `leaf_lo[6]`=1, `mem_type` is the entry type and the attribute-table type is ignored.
- R7: When `paging_en` is 0, the attribute-table type used for a translated access is WB, whatever the value of `pat_type`.
- R8: With `leaf_lo[6]`=0, the entry type and the effective attribute-table type combine in priority order. If either is UC, the result is UC. Otherwise, if either is WC, the result is WC. Otherwise, equal types give that type, WT with WB gives WT, WP with WB gives WP, and every other mix gives UC.
- R9: An attribute-table type of UC-minus (7) combines to WC when the entry type is WC and to UC in every other case.
- R10: `mem_type` only ever holds one of the codes 0, 1, 4, 5 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_dis | input | 1 | Global cache-disable control bit |
| paging_en | input | 1 | Guest paging-enable control bit |
| struct_fetch | input | 1 | 1 = translation-structure fetch, 0 = translated guest access |
| ptr_type | input | 3 | Type field of the translation root pointer |
| leaf_lo | input | LEAF_W (8) | Low bits of the final translation entry: type at [5:3], attribute-ignore at [6] |
| pat_type | input | 3 | Attribute-table type for the access |
| mem_type | output | 3 | Resolved memory type |
| misconfig | output | 1 | Illegal type field seen |

## Verification
The bench builds the block with its default parameters: an 8-bit entry slice, the type field at bit 3 and the ignore bit at bit 6. These defaults give 13 meaningful input bits, so every combination of the control bits, pointer code, entry code, ignore bit and attribute-table code can be swept in full. The sweep fills the entry bits that carry no meaning with random junk. A seeded random phase and a few directed cases for UC-minus and paging-off then check that unrelated fields are truly ignored when consecutive inputs differ.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
    localparam int MT_W = 3;

    localparam logic [MT_W-1:0] MT_UC  = 3'd0;
    localparam logic [MT_W-1:0] MT_WC  = 3'd1;
    localparam logic [MT_W-1:0] MT_WT  = 3'd4;
    localparam logic [MT_W-1:0] MT_WP  = 3'd5;
    localparam logic [MT_W-1:0] MT_WB  = 3'd6;
    localparam logic [MT_W-1:0] MT_UCM = 3'd7;

    typedef struct packed {
        logic [MT_W-1:0] mtype;
        logic            misconfig;
    } mtr_out_t;
endpackage

// File: rtl/mtr_code_check.sv
module mtr_code_check
    import mtr_pkg::*;
#(
    parameter bit FOR_POINTER = 1'b0
) (
    input  logic [MT_W-1:0] code,
    output logic            legal
);
    generate
        if (FOR_POINTER) begin : g_ptr
            always_comb legal = (code == MT_UC) || (code == MT_WB);
        end else begin : g_leaf
            always_comb legal = (code == MT_UC) || (code == MT_WC) ||
                                (code == MT_WT) || (code == MT_WP) ||
                                (code == MT_WB);
        end
    endgenerate
endmodule

// File: rtl/mtr_combine.sv
module mtr_combine
    import mtr_pkg::*;
(
    input  logic [MT_W-1:0] leaf_t,
    input  logic [MT_W-1:0] pat_t,
    output logic [MT_W-1:0] result
);
    always_comb begin
        if (pat_t == MT_UCM) begin
            result = (leaf_t == MT_WC) ? MT_WC : MT_UC;
        end else if (leaf_t == MT_UC || pat_t == MT_UC) begin
            result = MT_UC;
        end else if (leaf_t == MT_WC || pat_t == MT_WC) begin
            result = MT_WC;
        end else if (leaf_t == pat_t) begin
            result = leaf_t;
        end else if ((leaf_t == MT_WT && pat_t == MT_WB) ||
                     (leaf_t == MT_WB && pat_t == MT_WT)) begin
            result = MT_WT;
        end else if ((leaf_t == MT_WP && pat_t == MT_WB) ||
                     (leaf_t == MT_WB && pat_t == MT_WP)) begin
            result = MT_WP;
        end else begin
            result = MT_UC;
        end
    end
endmodule

// File: rtl/mem_type_resolver.sv
module mem_type_resolver
    import mtr_pkg::*;
#(
    parameter int LEAF_W        = 8,
    parameter int LEAF_TYPE_LSB = 3,
    parameter int LEAF_IPAT_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_dis,
    input  logic              paging_en,
    input  logic              struct_fetch,
    input  logic [MT_W-1:0]   ptr_type,
    input  logic [LEAF_W-1:0] leaf_lo,
    input  logic [MT_W-1:0]   pat_type,
    output logic [MT_W-1:0]   mem_type,
    output logic              misconfig
);
    localparam int LEAF_TYPE_MSB = LEAF_TYPE_LSB + MT_W - 1;

    logic [MT_W-1:0] leaf_type;
    logic            leaf_ipat;
    logic [MT_W-1:0] pat_eff;
    logic            ptr_legal;
    logic            leaf_legal;
    logic [MT_W-1:0] combined;
    mtr_out_t        out_d, out_q;

    assign leaf_type = leaf_lo[LEAF_TYPE_MSB:LEAF_TYPE_LSB];
    assign leaf_ipat = leaf_lo[LEAF_IPAT_BIT];
    assign pat_eff   = paging_en ? pat_type : MT_WB;

    mtr_code_check #(.FOR_POINTER(1'b1)) u_ptr_chk (
        .code  (ptr_type),
        .legal (ptr_legal)
    );

    mtr_code_check #(.FOR_POINTER(1'b0)) u_leaf_chk (
        .code  (leaf_type),
        .legal (leaf_legal)
    );

    mtr_combine u_comb (
        .leaf_t (leaf_type),
        .pat_t  (pat_eff),
        .result (combined)
    );

    always_comb begin
        out_d = '0;
        if (struct_fetch) begin
            out_d.misconfig = !ptr_legal;
            out_d.mtype     = (cache_dis || !ptr_legal) ? MT_UC : ptr_type;
        end else begin
            out_d.misconfig = !leaf_legal;
            if (cache_dis || !leaf_legal) begin
                out_d.mtype = MT_UC;
            end else if (leaf_ipat) begin
                out_d.mtype = leaf_type;
            end else begin
                out_d.mtype = combined;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign mem_type  = out_q.mtype;
    assign misconfig = out_q.misconfig;

    // R2
    cd_forces_uc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_dis |=> (mem_type == MT_UC));

    // R3
    ptr_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (struct_fetch && !cache_dis && ptr_type == MT_WB) |=> (mem_type == MT_WB && !misconfig));

    // R4
    ptr_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (struct_fetch && ptr_type != MT_UC && ptr_type != MT_WB) |=> (misconfig && mem_type == MT_UC));

    // R5
    leaf_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!struct_fetch && (leaf_type == 3'd2 || leaf_type == 3'd3 || leaf_type == 3'd7))
        |=> misconfig);

    // R6
    ipat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!struct_fetch && !cache_dis && leaf_ipat && leaf_legal) |=> (mem_type == $past(leaf_type)));

    // R7
    nopg_wt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!struct_fetch && !cache_dis && !paging_en && !leaf_ipat && leaf_type == MT_WT)
        |=> (mem_type == MT_WT));

    // R9
    ucm_wc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!struct_fetch && !cache_dis && paging_en && !leaf_ipat &&
         leaf_type == MT_WC && pat_type == MT_UCM) |=> (mem_type == MT_WC));

    // R4 R5
    flag_uc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misconfig |-> (mem_type == MT_UC));

    // R10
    legal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_type != 3'd2 && mem_type != 3'd3 && mem_type != 3'd7));
endmodule

// File: tb/mem_type_resolver_test.sv
module mem_type_resolver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cache_dis = 1'b0;
    logic       paging_en = 1'b0;
    logic       struct_fetch = 1'b0;
    logic [2:0] ptr_type = 3'd0;
    logic [7:0] leaf_lo = 8'd0;
    logic [2:0] pat_type = 3'd0;
    logic [2:0] mem_type;
    logic       misconfig;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mem_type_resolver uut (
        .clk(clk), .rst_n(rst_n), .cache_dis(cache_dis), .paging_en(paging_en),
        .struct_fetch(struct_fetch), .ptr_type(ptr_type), .leaf_lo(leaf_lo),
        .pat_type(pat_type), .mem_type(mem_type), .misconfig(misconfig)
    );

    function automatic bit legal_leaf(input logic [2:0] t);
        return (t == 3'd0 || t == 3'd1 || t == 3'd4 || t == 3'd5 || t == 3'd6);
    endfunction

    function automatic logic [2:0] mix(input logic [2:0] e, input logic [2:0] p);
        if (p == 3'd7) return (e == 3'd1) ? 3'd1 : 3'd0;
        if (e == 3'd0 || p == 3'd0) return 3'd0;
        if (e == 3'd1 || p == 3'd1) return 3'd1;
        if (e == p) return e;
        if ((e == 3'd4 && p == 3'd6) || (e == 3'd6 && p == 3'd4)) return 3'd4;
        if ((e == 3'd5 && p == 3'd6) || (e == 3'd6 && p == 3'd5)) return 3'd5;
        return 3'd0;
    endfunction

    // expected {misconfig, type}
    function automatic logic [3:0] model(input bit cd, input bit pg, input bit sf,
                                         input logic [2:0] ptr, input logic [7:0] leaf,
                                         input logic [2:0] pat);
        logic [2:0] e;
        logic [2:0] p;
        e = leaf[5:3];
        p = pg ? pat : 3'd6;
        if (sf) begin
            if (!(ptr == 3'd0 || ptr == 3'd6)) return {1'b1, 3'd0};
            return {1'b0, cd ? 3'd0 : ptr};
        end
        if (!legal_leaf(e)) return {1'b1, 3'd0};
        if (cd) return {1'b0, 3'd0};
        if (leaf[6]) return {1'b0, e};
        return {1'b0, mix(e, p)};
    endfunction

    function automatic string tag_of(input bit cd, input bit pg, input bit sf,
                                     input logic [2:0] ptr, input logic [7:0] leaf,
                                     input logic [2:0] pat);
        if (sf) begin
            if (!(ptr == 3'd0 || ptr == 3'd6)) return "R4";
            if (cd) return "R2";
            return "R3";
        end
        if (!legal_leaf(leaf[5:3])) return "R5";
        if (cd) return "R2";
        if (leaf[6]) return "R6";
        if (!pg) return "R7";
        if (pat == 3'd7) return "R9";
        return "R8";
    endfunction

    task automatic apply(input bit cd, input bit pg, input bit sf, input logic [2:0] ptr,
                         input logic [7:0] leaf, input logic [2:0] pat);
        logic [3:0] exp;
        string      tg;
        @(negedge clk);
        cache_dis = cd; paging_en = pg; struct_fetch = sf;
        ptr_type = ptr; leaf_lo = leaf; pat_type = pat;
        exp = model(cd, pg, sf, ptr, leaf, pat);
        tg  = tag_of(cd, pg, sf, ptr, leaf, pat);
        @(negedge clk);
        checks++;
        if ({misconfig, mem_type} !== exp) begin
            fails++;
            $display("FAIL %s: cd=%0b pg=%0b sf=%0b ptr=%0d leaf=%h pat=%0d got mis=%0b type=%0d exp mis=%0b type=%0d",
                     tg, cd, pg, sf, ptr, leaf, pat, misconfig, mem_type, exp[3], exp[2:0]);
        end
        // R10
        checks++;
        if (mem_type == 3'd2 || mem_type == 3'd3 || mem_type == 3'd7) begin
            fails++;
            $display("FAIL R10: mem_type=%0d expected one of 0,1,4,5,6", mem_type);
        end
    endtask

    function automatic logic [7:0] leaf_byte(input bit ipat, input logic [2:0] t,
                                             input logic [3:0] junk);
        return {junk[3], ipat, t, junk[2:0]};
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        cache_dis = 1'b1; struct_fetch = 1'b1; ptr_type = 3'd6;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (mem_type !== 3'd0 || misconfig !== 1'b0) begin
            fails++;
            $display("FAIL R1: got type=%0d mis=%0b exp type=0 mis=0", mem_type, misconfig);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (mem_type !== 3'd0 || misconfig !== 1'b0) begin
            fails++;
            $display("FAIL R1: after release got type=%0d mis=%0b exp type=0 mis=0", mem_type, misconfig);
        end

        // directed corners
        apply(0, 1, 1, 3'd6, 8'hFF, 3'd0);                    // R3 WB pointer
        apply(0, 1, 1, 3'd0, 8'h30, 3'd6);                    // R3 UC pointer
        apply(1, 1, 1, 3'd3, 8'h30, 3'd6);                    // R4 reserved under cd
        apply(0, 1, 0, 3'd5, leaf_byte(0, 3'd6, 0), 3'd4);    // R8 WB+WT -> WT
        apply(0, 1, 0, 3'd0, leaf_byte(0, 3'd5, 0), 3'd4);    // R8 WP+WT -> UC
        apply(0, 1, 0, 3'd0, leaf_byte(0, 3'd1, 0), 3'd7);    // R9 WC+UCM -> WC
        apply(0, 1, 0, 3'd0, leaf_byte(0, 3'd6, 0), 3'd7);    // R9 WB+UCM -> UC
        apply(0, 1, 0, 3'd0, leaf_byte(1, 3'd5, 0), 3'd0);    // R6 ignore table
        apply(0, 0, 0, 3'd0, leaf_byte(0, 3'd4, 0), 3'd0);    // R7 paging off
        apply(1, 1, 0, 3'd0, leaf_byte(0, 3'd7, 0), 3'd6);    // R5 reserved under cd
        apply(1, 0, 0, 3'd6, leaf_byte(1, 3'd6, 0), 3'd6);    // R2 translated

        // exhaustive sweep with junk in unused entry bits
        for (int i = 0; i < 8192; i++) begin
            logic [12:0] v;
            v = i[12:0];
            apply(v[0], v[1], v[2], v[5:3],
                  leaf_byte(v[6], v[9:7], 4'($urandom_range(0, 15))), v[12:10]);
        end

        // random phase
        for (int i = 0; i < 2000; i++) begin
            apply(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                  8'($urandom_range(0, 255)), 3'($urandom_range(0, 7)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule